// File: doc/BRIEF.md
# Block-Pipelined Survivor Traceback Unit

This unit sits behind the add-compare-select stage of a 64-state, rate 1/2 convolutional decoder. Each accepted step delivers one 64-bit survivor decision vector, with one bit per trellis state. Vectors are written in turn into four memory banks of `BLOCK_LEN` entries. The banks rotate each time a block of `BLOCK_LEN` accepted steps is complete.

When a block completes, two passes of `BLOCK_LEN` cycles each start together. The first pass is a traceback only. It walks the newest block backwards from the best-metric state that came with that block's last vector, and ends on the state at the block's start. The second pass is a decode. It walks the block that is two blocks older, starting from the state that the previous traceback found, and produces that block's bits newest first. These bits are collected in a reversal buffer. When the decode finishes, the whole block is moved into an output register and released one bit per cycle, earliest step first. Until real data has reached the decode pass, the unit emits zero bits with the valid flag set. The output stream therefore lags the input by a fixed `2*BLOCK_LEN` bits.

A block length near ten constraint lengths (about 64 to 70 for constraint length 7) gives good error performance. The default is 64.

Top module: `trellis_backtrace_dec`

## Requirements
- R1: A decision vector (bit s holds the survivor choice of state s) is stored only in a cycle where `decValid` is high. Every `BLOCK_LEN` stored vectors form one block. `decVec` and `bestState` in cycles with `decValid` low have no effect on the output.
- R2: The traceback of a block starts from the `bestState` presented together with that block's last accepted vector. `bestState` presented with any other vector is ignored.
- R3: One backward step from state s reads d = bit s of that step's vector and moves to state {s[4:0], d}. The bit decoded for that step is s[5].
- R4: Each completed block yields exactly `BLOCK_LEN` output bits. They are released one per cycle with `bitValid` high, in forward time order. The first bit is visible `BLOCK_LEN + 1` cycles after the clock edge that accepted the block's last vector.
- R5: The first `2*BLOCK_LEN` output bits after reset are zero. After that, output bit n is the encoder input of accepted step n - `2*BLOCK_LEN`.
- R6: When vectors arrive every cycle, `bitValid` stays high with no gap from one output burst to the next.
- R7: While reset is asserted, and after it, `bitValid` and `bitOut` are low. `bitValid` stays low until the first block has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| decValid | input | 1 | Decision vector valid for this cycle |
| decVec | input | 64 | Survivor decision bits, one per state |
| bestState | input | 6 | Minimum-metric state for the current step |
| bitValid | output | 1 | Decoded bit valid |
| bitOut | output | 1 | Decoded bit, forward time order |

## Verification
With vectors arriving every cycle, three events land on the same clock edge: the final step of one traceback, the start of the next traceback, and the start of a decode that needs the state the finishing traceback has just computed. On that same edge the last decode step also hands its block to the output register while the previous burst releases its final bit. Back-to-back blocks provoke this overlap. It is judged by exact bit-for-bit comparison of the output stream against the message, by a check that `bitValid` shows no hole between bursts, and by a check of the first-bit latency. Blocks with idle gaps, carrying garbage vectors and garbage best states, show that only accepted vectors and the block-final best state matter.

// File: rtl/bktr_pkg.sv
package bktr_pkg;

  localparam int STATE_W   = 6;
  localparam int NUM_STATE = 1 << STATE_W;
  localparam int NUM_BANKS = 4;
  localparam int BANK_W    = $clog2(NUM_BANKS);

  typedef struct packed {
    logic wrEn;      // store incoming vector
    logic tbLoad;    // traceback pass starts from bestState
    logic tbStep;    // one traceback step
    logic decLoad;   // decode pass starts from traceback result
    logic decStep;   // one decode step
    logic decReal;   // decode block holds real data
    logic outLoad;   // move reversed block to output register
    logic outShift;  // release one output bit
  } bktrStrobes_t;

  // predecessor of state s along the survivor with decision bit d
  function automatic logic [STATE_W-1:0] prevState(input logic [STATE_W-1:0] s,
                                                   input logic d);
    return {s[STATE_W-2:0], d};
  endfunction

endpackage

// File: rtl/bktr_ctrl.sv
module bktr_ctrl
  import bktr_pkg::*;
#(
  parameter  int BLOCK_LEN = 64,
  localparam int ADDR_W    = $clog2(BLOCK_LEN),
  localparam int IDX_W     = $clog2(NUM_BANKS * BLOCK_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              decValid,
  output bktrStrobes_t      strb,
  output logic [IDX_W-1:0]  wrIdx,
  output logic [IDX_W-1:0]  tbIdx,
  output logic [IDX_W-1:0]  decIdx,
  output logic [ADDR_W-1:0] decAddrOut,
  output logic              bitValid
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(BLOCK_LEN - 1);
  localparam logic [ADDR_W:0]   BURST_LEN = (ADDR_W + 1)'(BLOCK_LEN);

  logic [ADDR_W-1:0] wrPtr, tbAddr, decAddr;
  logic [BANK_W-1:0] wrBank, tbBank, decBank;
  logic              tbActive, decActive, decReal;
  logic [1:0]        blocksSeen;
  logic [ADDR_W:0]   outCnt;
  logic              blockEnd, outLoad;

  function automatic logic [IDX_W-1:0] bankIdx(input logic [BANK_W-1:0] bank,
                                               input logic [ADDR_W-1:0] addr);
    return IDX_W'(int'(bank) * BLOCK_LEN + int'(addr));
  endfunction

  assign blockEnd = decValid && (wrPtr == LAST_ADDR);
  assign outLoad  = decActive && (decAddr == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr      <= '0;
      wrBank     <= '0;
      tbBank     <= '0;
      decBank    <= '0;
      tbAddr     <= '0;
      decAddr    <= '0;
      tbActive   <= 1'b0;
      decActive  <= 1'b0;
      decReal    <= 1'b0;
      blocksSeen <= '0;
      outCnt     <= '0;
    end else begin
      if (decValid) begin
        wrPtr <= blockEnd ? '0 : wrPtr + 1'b1;
      end
      if (blockEnd) begin
        wrBank    <= wrBank + 1'b1;
        tbBank    <= wrBank;
        decBank   <= wrBank - BANK_W'(2);
        tbActive  <= 1'b1;
        tbAddr    <= LAST_ADDR;
        decActive <= 1'b1;
        decAddr   <= LAST_ADDR;
        decReal   <= (blocksSeen == 2'd2);
        if (blocksSeen != 2'd2) blocksSeen <= blocksSeen + 1'b1;
      end else begin
        if (tbActive) begin
          if (tbAddr == '0) tbActive <= 1'b0;
          else              tbAddr   <= tbAddr - 1'b1;
        end
        if (decActive) begin
          if (decAddr == '0) decActive <= 1'b0;
          else               decAddr   <= decAddr - 1'b1;
        end
      end
      if (outLoad)           outCnt <= BURST_LEN;
      else if (outCnt != '0) outCnt <= outCnt - 1'b1;
    end
  end

  always_comb begin
    strb.wrEn     = decValid;
    strb.tbLoad   = blockEnd;
    strb.tbStep   = tbActive;
    strb.decLoad  = blockEnd;
    strb.decStep  = decActive;
    strb.decReal  = decReal;
    strb.outLoad  = outLoad;
    strb.outShift = (outCnt != '0) && !outLoad;
  end

  assign wrIdx      = bankIdx(wrBank, wrPtr);
  assign tbIdx      = bankIdx(tbBank, tbAddr);
  assign decIdx     = bankIdx(decBank, decAddr);
  assign decAddrOut = decAddr;
  assign bitValid   = (outCnt != '0);

endmodule

// File: rtl/bktr_datapath.sv
module bktr_datapath
  import bktr_pkg::*;
#(
  parameter  int BLOCK_LEN = 64,
  localparam int ADDR_W    = $clog2(BLOCK_LEN),
  localparam int IDX_W     = $clog2(NUM_BANKS * BLOCK_LEN)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  bktrStrobes_t         strb,
  input  logic [NUM_STATE-1:0] decVec,
  input  logic [STATE_W-1:0]   bestState,
  input  logic [IDX_W-1:0]     wrIdx,
  input  logic [IDX_W-1:0]     tbIdx,
  input  logic [IDX_W-1:0]     decIdx,
  input  logic [ADDR_W-1:0]    decAddr,
  output logic                 bitOut
);

  logic [NUM_STATE-1:0] survMem [NUM_BANKS * BLOCK_LEN];

  logic [STATE_W-1:0]   tbState, decState, tbNext, decNext, decStart;
  logic [BLOCK_LEN-1:0] revBuf, revNext, outBuf;
  logic                 decBitNow;

  always_ff @(posedge clk) begin
    if (strb.wrEn) survMem[wrIdx] <= decVec;
  end

  assign tbNext    = prevState(tbState, survMem[tbIdx][tbState]);
  assign decNext   = prevState(decState, survMem[decIdx][decState]);
  // a traceback finishing on the same edge hands over its final state directly
  assign decStart  = strb.tbStep ? tbNext : tbState;
  assign decBitNow = strb.decReal & decState[STATE_W-1];

  always_comb begin
    revNext          = revBuf;
    revNext[decAddr] = decBitNow;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbState  <= '0;
      decState <= '0;
      revBuf   <= '0;
      outBuf   <= '0;
    end else begin
      if (strb.tbLoad)      tbState <= bestState;
      else if (strb.tbStep) tbState <= tbNext;

      if (strb.decLoad)      decState <= decStart;
      else if (strb.decStep) decState <= decNext;

      if (strb.decStep) revBuf <= revNext;

      if (strb.outLoad)       outBuf <= revNext;
      else if (strb.outShift) outBuf <= outBuf >> 1;
    end
  end

  assign bitOut = outBuf[0];

endmodule

// File: rtl/trellis_backtrace_dec.sv
module trellis_backtrace_dec
  import bktr_pkg::*;
#(
  parameter int BLOCK_LEN = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        decValid,
  input  logic [63:0] decVec,
  input  logic [5:0]  bestState,
  output logic        bitValid,
  output logic        bitOut
);

  localparam int ADDR_W = $clog2(BLOCK_LEN);
  localparam int IDX_W  = $clog2(NUM_BANKS * BLOCK_LEN);

  bktrStrobes_t      strb;
  logic [IDX_W-1:0]  wrIdx, tbIdx, decIdx;
  logic [ADDR_W-1:0] decAddr;

  bktr_ctrl #(.BLOCK_LEN(BLOCK_LEN)) ctrlI (
    .clk        (clk),
    .rst_n      (rst_n),
    .decValid   (decValid),
    .strb       (strb),
    .wrIdx      (wrIdx),
    .tbIdx      (tbIdx),
    .decIdx     (decIdx),
    .decAddrOut (decAddr),
    .bitValid   (bitValid)
  );

  bktr_datapath #(.BLOCK_LEN(BLOCK_LEN)) dpI (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .decVec    (decVec),
    .bestState (bestState),
    .wrIdx     (wrIdx),
    .tbIdx     (tbIdx),
    .decIdx    (decIdx),
    .decAddr   (decAddr),
    .bitOut    (bitOut)
  );

endmodule

// File: rtl/trellis_backtrace_dec_chk.sv
module trellis_backtrace_dec_chk #(
  parameter int BLOCK_LEN = 64
) (
  input logic clk,
  input logic rst_n,
  input logic decValid,
  input logic bitValid,
  input logic bitOut
);

  logic [31:0] stepMod, blocks, emitted, emitMod;
  logic        sawBlock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stepMod  <= '0;
      blocks   <= '0;
      emitted  <= '0;
      emitMod  <= '0;
      sawBlock <= 1'b0;
    end else begin
      if (decValid) begin
        if (stepMod == 32'(BLOCK_LEN - 1)) begin
          stepMod  <= '0;
          blocks   <= blocks + 1;
          sawBlock <= 1'b1;
        end else begin
          stepMod <= stepMod + 1;
        end
      end
      if (bitValid) begin
        emitted <= emitted + 1;
        emitMod <= (emitMod == 32'(BLOCK_LEN - 1)) ? '0 : emitMod + 1;
      end
    end
  end

  // R7
  no_early_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sawBlock |-> !bitValid);

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bitValid |-> (emitted < blocks * 32'(BLOCK_LEN)));

  // R5
  no_leading_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bitValid && (emitted < 32'(2 * BLOCK_LEN))) |-> !bitOut);

  // R6
  no_midburst_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bitValid) |-> (emitMod == '0));

endmodule

bind trellis_backtrace_dec trellis_backtrace_dec_chk #(.BLOCK_LEN(BLOCK_LEN)) chkI (
  .clk      (clk),
  .rst_n    (rst_n),
  .decValid (decValid),
  .bitValid (bitValid),
  .bitOut   (bitOut)
);

// File: tb/trellis_backtrace_dec_tb_top.sv
`timescale 1ns/1ps
module trellis_backtrace_dec_tb_top;

  localparam int M    = 16;
  localparam int NTAB = 8;
  localparam int MAXB = 512;
  // {message word (LSB first), idle cycles after each accepted step}
  localparam logic [19:0] STIM [NTAB] = '{
    {16'hA5C3, 4'd0}, {16'hFFFF, 4'd0}, {16'h0000, 4'd1}, {16'h1234, 4'd3},
    {16'h8001, 4'd0}, {16'hDEAD, 4'd2}, {16'h5555, 4'd0}, {16'hBEEF, 4'd5}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        decValid = 1'b0;
  logic [63:0] decVec = '0;
  logic [5:0]  bestState = '0;
  logic        bitValid, bitOut;

  int   checks = 0, fails = 0;
  logic expBits [MAXB];
  int   fedCnt = 0, outIdx = 0, cyc = 0;
  int   firstV = -1, lastV = -1, vCount = 0, bndCyc = 0;
  logic [6:0] hist = '0;

  always #2 clk = ~clk;

  trellis_backtrace_dec #(.BLOCK_LEN(M)) dut_i (
    .clk(clk), .rst_n(rst_n), .decValid(decValid), .decVec(decVec),
    .bestState(bestState), .bitValid(bitValid), .bitOut(bitOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // one accepted step of the encoder path; other states get random decisions
  task automatic feedStep(input logic b, input int gap, input bit last);
    logic [63:0] vec;
    hist = {b, hist[6:1]};
    vec = {$urandom, $urandom};
    vec[hist[6:1]] = hist[0];
    decVec    = vec;
    decValid  = 1'b1;
    bestState = last ? hist[6:1] : 6'($urandom);
    expBits[fedCnt] = b;
    fedCnt++;
    @(posedge clk); #1;
    if (last) bndCyc = cyc;
    decValid  = 1'b0;
    decVec    = {$urandom, $urandom};
    bestState = 6'($urandom);
    for (int g = 0; g < gap; g++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic feedBlock(input logic [15:0] word, input int gap);
    for (int i = 0; i < M; i++) feedStep(word[i], gap, i == M - 1);
  endtask

  // output monitor, sampled away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      outIdx = 0;
    end else if (bitValid) begin
      logic exp;
      exp = (outIdx < 2 * M) ? 1'b0 : expBits[outIdx - 2 * M];
      if (outIdx < 2 * M)
        check(bitOut === exp, "R5 leading zero bit", int'(bitOut), int'(exp));
      else
        check(bitOut === exp, "R1/R2/R3 decoded bit", int'(bitOut), int'(exp));
      outIdx++;
      vCount++;
      if (firstV < 0) firstV = cyc;
      lastV = cyc;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < MAXB; i++) expBits[i] = 1'b0;
    repeat (3) @(posedge clk); #1;
    // R7 reset state
    check(bitValid == 1'b0, "R7 bitValid in reset", int'(bitValid), 0);
    check(bitOut == 1'b0, "R7 bitOut in reset", int'(bitOut), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // table-driven stream: back-to-back and gapped blocks (R1, R2)
    for (int t = 0; t < NTAB; t++) begin
      feedBlock(STIM[t][19:4], int'(STIM[t][3:0]));
      if (t == 0) check(bitValid == 1'b0, "R7 no output at first block end", int'(bitValid), 0);
    end
    // flush so the last table blocks get decoded
    for (int f = 0; f < 2; f++) feedBlock(16'($urandom), 0);
    repeat (3 * M) @(posedge clk); #1;
    check(outIdx == (NTAB + 2) * M, "R4 bits per block", outIdx, (NTAB + 2) * M);
    check(bitValid == 1'b0, "R4 output idle after drain", int'(bitValid), 0);

    // directed: reset mid-run, then back-to-back blocks
    rst_n = 1'b0;
    @(posedge clk); #1;
    check(bitValid == 1'b0, "R7 bitValid after reset", int'(bitValid), 0);
    hist = '0; fedCnt = 0;
    vCount = 0; firstV = -1; lastV = -1;
    rst_n = 1'b1;
    begin
      int b0;
      feedBlock(16'hC3A5, 0);
      b0 = bndCyc;
      feedBlock(16'h0F0F, 0);
      feedBlock(16'h9696, 0);
      feedBlock(16'h7E81, 0);
      repeat (3 * M) @(posedge clk); #1;
      // R4 first bit latency
      check(firstV - b0 == M + 1, "R4 first bit latency", firstV - b0, M + 1);
    end
    check(vCount == 4 * M, "R4 bit count after back-to-back", vCount, 4 * M);
    check(lastV - firstV + 1 == vCount, "R6 continuous bursts", lastV - firstV + 1, vCount);

    summary();
    $finish;
  end

endmodule